// File: doc/BRIEF.md
# Deserializer Reset and Alignment Sequencer

This block sequences the bring-up of a bank of source-synchronous input deserializers. All of its logic runs on the divided capture clock, which is the same clock the deserializers use for their parallel side. It holds the deserializer reset high until both delay-calibration controllers report ready. It then waits a fixed number of divided-clock cycles and releases the reset, so that the release is synchronous to that clock. After a second fixed wait, it fires a single-cycle pulse that restarts the word-alignment state machines.

Two asynchronous request lines can restart the whole sequence at any moment: one from a push button and one from a processor GPIO. The two calibration-ready lines are also asynchronous. All four pass through a two-flop synchronizer before the state machine uses them. A request, or the loss of either ready, forces the block back into the hold state within two clock edges. A busy/done pair tells software when the sequence has finished.

Top module: `deser_rst_seq`

## Requirements
- R1: While `rst_n` is low, `serdes_rst` is 1, `align_start` is 0, `seq_busy` is 1 and `seq_done` is 0.
- R2: `serdes_rst` stays 1 for as long as `cal_rdy_a` or `cal_rdy_b` is low.
- R3: Call the first rising edge at which both readies are sampled high and both requests are sampled low the clear edge. `serdes_rst` falls right after the edge that comes 2+REL_WAIT edges later (5 with defaults), provided that condition holds throughout. If the condition breaks inside that window, `serdes_rst` does not fall.
- R4: `align_start` is a one-cycle pulse. It goes high right after the edge that comes ALN_WAIT edges (3) after the edge that released `serdes_rst`. It is only ever high while `serdes_rst` is 0.
- R5: `seq_done` rises on the edge after the `align_start` pulse and then stays 1, with `seq_busy` 0. `seq_busy` is the inverse of `seq_done`.
- R6: Either `btn_req` or `gpio_req` (active high) restarts the sequence at any time. `serdes_rst` rises right after the second edge following the first edge at which the request is sampled high. It stays high while the request is held. After the request is released, the timing of R3 applies.
- R7: If either ready goes low after the sequence has completed, `serdes_rst` rises 2 edges after the drop is sampled. `seq_done` falls at the same time.
- R8: A request that arrives between reset release and the alignment pulse cancels the pending `align_start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_div | input | 1 | Divided capture clock |
| rst_n | input | 1 | Asynchronous block reset, active low, deassertion synchronized internally |
| btn_req | input | 1 | Asynchronous push-button restart request, active high |
| gpio_req | input | 1 | Asynchronous processor restart request, active high |
| cal_rdy_a | input | 1 | Ready from first delay-calibration controller (async) |
| cal_rdy_b | input | 1 | Ready from second delay-calibration controller (async) |
| serdes_rst | output | 1 | Deserializer reset, active high, released synchronously |
| align_start | output | 1 | One-cycle word-alignment restart pulse |
| seq_busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | Sequence finished |

## Verification
The sequencer is driven through a clean first bring-up in which one ready arrives well before the other. This separates correct gating on both readies from gating on only one of them. It is then retriggered from the GPIO line and from the push button, the button press landing in the gap between reset release and the alignment pulse, which shows whether the pending pulse is cancelled. Ready drops are applied after completion and inside the release window. These show whether the fixed wait restarts from the latest clear edge or only counts elapsed cycles. Every edge of `serdes_rst`, `align_start` and `seq_done` is checked against the exact clock index at which it is expected.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  typedef enum logic [2:0] {
    ST_HOLD     = 3'd0,
    ST_WAIT_REL = 3'd1,
    ST_WAIT_ALN = 3'd2,
    ST_KICK     = 3'd3,
    ST_DONE     = 3'd4
  } seq_state_t;

  // larger of two counts
  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // counter width able to hold value n
  function automatic int unsigned width_for(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // a wait of lim cycles is over when the in-state count reaches lim-1
  function automatic bit wait_over(int unsigned cnt, int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/dsq_rst_bridge.sv
module dsq_rst_bridge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '1;
    else         chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst_o = chain[STAGES-1];
endmodule

// File: rtl/dsq_sync.sv
module dsq_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= '0;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= '0;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dsq_timer.sv
module dsq_timer #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dsq_fsm.sv
module dsq_fsm
  import dsq_pkg::*;
#(
  parameter int unsigned REL_WAIT = 3,
  parameter int unsigned ALN_WAIT = 3,
  parameter int unsigned CW       = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_s,
  input  logic [1:0]    rdy_s,
  input  logic [CW-1:0] cnt,
  output logic          timer_clr,
  output logic          serdes_rst,
  output logic          align_start,
  output logic          seq_busy,
  output logic          seq_done
);
  localparam int unsigned RUN_MAX = REL_WAIT + 2;
  localparam int unsigned RW      = width_for(RUN_MAX);

  seq_state_t state, nxt;
  logic       ok_s;
  logic       rel_evt;
  logic       kick_evt;

  assign ok_s = !req_s && (&rdy_s);

  always_comb begin
    nxt = state;
    if (!ok_s) begin
      nxt = ST_HOLD;
    end else begin
      unique case (state)
        ST_HOLD:     nxt = ST_WAIT_REL;
        ST_WAIT_REL: if (wait_over(int'(cnt), REL_WAIT)) nxt = ST_WAIT_ALN;
        ST_WAIT_ALN: if (wait_over(int'(cnt), ALN_WAIT)) nxt = ST_KICK;
        ST_KICK:     nxt = ST_DONE;
        ST_DONE:     nxt = ST_DONE;
        default:     nxt = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_HOLD;
    else     state <= nxt;
  end

  assign timer_clr   = (nxt != state);
  assign rel_evt     = (state == ST_WAIT_REL) && (nxt == ST_WAIT_ALN);
  assign kick_evt    = (state == ST_WAIT_ALN) && (nxt == ST_KICK);
  assign serdes_rst  = (state == ST_HOLD) || (state == ST_WAIT_REL);
  assign align_start = (state == ST_KICK);
  assign seq_done    = (state == ST_DONE);
  assign seq_busy    = !seq_done;

  // checker-side run length of the clear condition
  logic [RW-1:0] gate_run;
  always_ff @(posedge clk) begin
    if (rst || !ok_s)                 gate_run <= '0;
    else if (gate_run != RW'(RUN_MAX)) gate_run <= gate_run + 1'b1;
  end

  // R2
  blocked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ok_s |=> serdes_rst);

  // R3
  release_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(serdes_rst) |-> gate_run == RW'(REL_WAIT + 1));

  // R3
  release_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rel_evt |-> ok_s);

  // R4
  kick_single_chk: assert property (@(posedge clk) disable iff (rst)
    align_start |=> !align_start);

  // R4
  kick_released_chk: assert property (@(posedge clk) disable iff (rst)
    kick_evt |=> align_start && !serdes_rst);

  // R5
  done_after_kick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_done) |-> $past(align_start));

  // R8
  req_cancels_kick_chk: assert property (@(posedge clk) disable iff (rst)
    req_s |=> !align_start);
endmodule

// File: rtl/deser_rst_seq.sv
module deser_rst_seq
  import dsq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REL_WAIT    = 3,
  parameter int unsigned ALN_WAIT    = 3
) (
  input  logic clk_div,
  input  logic rst_n,
  input  logic btn_req,
  input  logic gpio_req,
  input  logic cal_rdy_a,
  input  logic cal_rdy_b,
  output logic serdes_rst,
  output logic align_start,
  output logic seq_busy,
  output logic seq_done
);
  localparam int unsigned CW = width_for(max2(REL_WAIT, ALN_WAIT));

  logic          rst_i;
  logic [3:0]    raw;
  logic [3:0]    synced;
  logic          req_s;
  logic [1:0]    rdy_s;
  logic [CW-1:0] cnt;
  logic          timer_clr;

  dsq_rst_bridge #(.STAGES(SYNC_STAGES)) u_bridge (
    .clk(clk_div), .arst_n(rst_n), .rst_o(rst_i)
  );

  assign raw = {btn_req, gpio_req, cal_rdy_b, cal_rdy_a};

  dsq_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_div), .rst(rst_i), .d(raw), .q(synced)
  );

  assign req_s = synced[3] | synced[2];
  assign rdy_s = synced[1:0];

  dsq_timer #(.W(CW)) u_timer (
    .clk(clk_div), .rst(rst_i), .clr(timer_clr), .cnt(cnt)
  );

  dsq_fsm #(.REL_WAIT(REL_WAIT), .ALN_WAIT(ALN_WAIT), .CW(CW)) u_fsm (
    .clk(clk_div), .rst(rst_i), .req_s(req_s), .rdy_s(rdy_s),
    .cnt(cnt), .timer_clr(timer_clr), .serdes_rst(serdes_rst),
    .align_start(align_start), .seq_busy(seq_busy), .seq_done(seq_done)
  );

  // R1
  reset_hold_chk: assert property (@(posedge clk_div)
    !rst_n |=> serdes_rst && !align_start && seq_busy);
endmodule

// File: tb/tb_deser_rst_seq.sv
module tb_deser_rst_seq;
  localparam int LAT_REQ = 2;
  localparam int REL     = 3;
  localparam int ALN     = 3;

  typedef enum int { EV_FALL, EV_RISE, EV_ALIGN, EV_DONE } ev_kind_t;
  typedef struct { ev_kind_t kind; int at; } ev_t;

  logic clk = 0;
  logic rst_n = 0;
  logic btn_req = 0, gpio_req = 0, cal_rdy_a = 0, cal_rdy_b = 0;
  logic serdes_rst, align_start, seq_busy, seq_done;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int align_seen = 0;
  bit mon_en = 0;
  ev_t exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  deser_rst_seq dut (
    .clk_div(clk), .rst_n(rst_n), .btn_req(btn_req), .gpio_req(gpio_req),
    .cal_rdy_a(cal_rdy_a), .cal_rdy_b(cal_rdy_b), .serdes_rst(serdes_rst),
    .align_start(align_start), .seq_busy(seq_busy), .seq_done(seq_done)
  );

  task automatic check(string req, logic act, logic expv, string what);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, expv);
    end
  endtask

  task automatic push(ev_kind_t k, int at);
    ev_t e;
    e.kind = k; e.at = at;
    exp_q.push_back(e);
  endtask

  // inputs cleared at the negedge before clear edge n+1
  task automatic expect_release(int n);
    push(EV_FALL,  n + 1 + LAT_REQ + REL);      // R3
    push(EV_ALIGN, n + 1 + LAT_REQ + REL + ALN); // R4
    push(EV_DONE,  n + 2 + LAT_REQ + REL + ALN); // R5
  endtask

  task automatic expect_hold(int n);
    push(EV_RISE, n + 1 + LAT_REQ);
  endtask

  task automatic observe(ev_kind_t k, string req);
    ev_t e;
    total++;
    if (exp_q.size() == 0) begin
      bad++;
      $display("FAIL %s unexpected event: actual=%s@%0d expected=none",
               req, k.name(), cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != k || e.at != cyc) begin
        bad++;
        $display("FAIL %s event: actual=%s@%0d expected=%s@%0d",
                 req, k.name(), cyc, e.kind.name(), e.at);
      end
    end
  endtask

  // monitor
  logic prev_rst = 1, prev_done = 0, prev_align = 0;
  always @(negedge clk) begin
    if (mon_en) begin
      if (serdes_rst !== prev_rst)
        observe(serdes_rst ? EV_RISE : EV_FALL, serdes_rst ? "R6" : "R3");
      if (align_start) begin
        align_seen++;
        observe(EV_ALIGN, "R4");
        if (prev_align) begin
          total++; bad++;
          $display("FAIL R4 pulse width: actual=2+ expected=1");
        end
      end
      if (seq_done && !prev_done) observe(EV_DONE, "R5");
    end
    prev_rst = serdes_rst;
    prev_done = seq_done;
    prev_align = align_start;
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int n;
    int a0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", serdes_rst, 1'b1, "serdes_rst in reset");
    check("R1", align_start, 1'b0, "align_start in reset");
    check("R1", seq_busy, 1'b1, "busy in reset");
    check("R1", seq_done, 1'b0, "done in reset");
    rst_n = 1;
    repeat (5) @(negedge clk);
    mon_en = 1;

    // R2: only one ready
    cal_rdy_a = 1;
    repeat (10) @(negedge clk);
    check("R2", serdes_rst, 1'b1, "held with one ready");
    check("R2", seq_busy, 1'b1, "busy with one ready");
    cal_rdy_b = 1; n = cyc; expect_release(n);
    repeat (14) @(negedge clk);
    check("R5", seq_done, 1'b1, "done after first run");
    check("R5", seq_busy, 1'b0, "busy after first run");
    check("R3", serdes_rst, 1'b0, "released after first run");

    // R6: GPIO retrigger
    gpio_req = 1; n = cyc; expect_hold(n);
    repeat (5) @(negedge clk);
    check("R6", seq_done, 1'b0, "done cleared by gpio");
    check("R6", serdes_rst, 1'b1, "reset held by gpio");
    gpio_req = 0; n = cyc; expect_release(n);
    repeat (14) @(negedge clk);
    check("R6", seq_done, 1'b1, "done after gpio run");

    // R8: button during post-release wait
    gpio_req = 1; n = cyc; expect_hold(n);
    repeat (4) @(negedge clk);
    gpio_req = 0; n = cyc;
    push(EV_FALL, n + 1 + LAT_REQ + REL);
    repeat (1 + LAT_REQ + REL) @(negedge clk);
    a0 = align_seen;
    btn_req = 1; n = cyc; expect_hold(n);
    repeat (8) @(negedge clk);
    total++;
    if (align_seen != a0) begin
      bad++;
      $display("FAIL R8 cancelled pulse: actual=%0d expected=0", align_seen - a0);
    end
    check("R8", serdes_rst, 1'b1, "held by button");
    btn_req = 0; n = cyc; expect_release(n);
    repeat (14) @(negedge clk);
    check("R6", seq_done, 1'b1, "done after button run");

    // R7: ready drop after completion
    cal_rdy_a = 0; n = cyc; expect_hold(n);
    repeat (5) @(negedge clk);
    check("R7", seq_done, 1'b0, "done dropped with ready");
    check("R7", serdes_rst, 1'b1, "reset on ready loss");
    cal_rdy_a = 1; n = cyc; expect_release(n);
    repeat (14) @(negedge clk);
    check("R7", seq_done, 1'b1, "done after recovery");

    // R3: ready glitch inside release window
    cal_rdy_b = 0; n = cyc; expect_hold(n);
    repeat (5) @(negedge clk);
    cal_rdy_b = 1;
    repeat (3) @(negedge clk);
    cal_rdy_b = 0;
    repeat (8) @(negedge clk);
    check("R3", serdes_rst, 1'b1, "no release after broken window");
    cal_rdy_b = 1; n = cyc; expect_release(n);
    repeat (14) @(negedge clk);
    check("R3", serdes_rst, 1'b0, "released after clean window");

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R3 missing events: actual=%0d expected=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule